// File: doc/BRIEF.md
# Shutdown and Wake-Up Controller

This block holds the main-supply enable of a chip that can be powered down and woken again. It runs on a 32.768 kHz always-on slow clock and presents four 32-bit registers on a small register bus with write strobe, read strobe and byte address. Software powers the chip down by writing a shutdown command together with an 8-bit password to the command register. One slow-clock cycle later the block pulls the supply-enable output low.

While the supply is off, the block watches up to sixteen external wake pins and a pulse from a real-time-clock alarm. Each pin has its own enable bit and its own active-level bit. All pins share a debounce length, selected from six settings: no filtering, or 3, 32, 512, 4096 or 32768 slow-clock cycles (about one second at the longest). Each pin keeps its own counter. A pin wakes the chip once it has stayed active for the selected number of synchronized samples. An alarm pulse wakes the chip at once if alarm wake is enabled. On the wake edge the supply enable rises again, and a status register records every source that qualified on that edge. Reading the status register clears it.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, supply_en is 1 and the status register at offset 0x08 reads 0.
- R2: A write to offset 0x00 with bit 0 set and bits 31:24 equal to 0xA5 drives supply_en low on the clock edge that takes the write, so supply_en is already low in the cycle after the write.
- R3: A write to offset 0x00 with any other key in bits 31:24, or with bit 0 clear, leaves supply_en high.
- R4: The mode register at 0x04 keeps the debounce code in bits 26:24 and the alarm-wake enable in bit 17, and reads back only those bits. The wake configuration register at 0x0C holds the pin enables in bits 15:0 and the pin levels in bits 31:16 (1 = active high, 0 = active low), and reads back in full. Offset 0x00 reads 0.
- R5: While the supply is off, a pin counts as active only when its enable bit is 1 and its level equals its selected level. A disabled pin, or a pin at the other level, never wakes the chip.
- R6: Debounce codes 0 to 5 require 1, 3, 32, 512, 4096 and 32768 consecutive active samples; codes 6 and 7 behave as code 5. Pins pass through a two-stage synchronizer. When a pin becomes active just before clock edge e and stays active, supply_en is high after edge e+N+1, where N is the required count.
- R7: A pin that goes inactive for at least one synchronized sample restarts its count from zero.
- R8: While the supply is off and mode bit 17 is 1, a one-cycle pulse on rtc_alarm sets supply_en high on that edge and sets status bit 5. When bit 17 is 0, the pulse has no effect.
- R9: On the wake edge, status bit 16+n is set for every pin n that qualified on that edge. A read of offset 0x08 returns the status and then clears it to 0.
- R10: While the supply is on, active pins and alarm pulses leave the status register unchanged.
- R11: With 0 written to both 0x04 and 0x0C, no pin level and no alarm pulse ends a shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status at 0x08) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wake_pin | input | NUM_WAKE | External wake pins, asynchronous |
| rtc_alarm | input | 1 | One-cycle alarm pulse from the real-time clock |
| supply_en | output | 1 | Main-supply enable, high while powered |

## Verification
The cases that are hardest to reach are a debounce count that breaks off partway and then starts again, and a wake where the exact edge matters. Both can only be reached from the shut-down state, after a keyed write and with a matching pin configuration. The bench therefore runs every test as a full cycle of configure, shut down, drive the pin and wait. It counts clock edges from the pin change to the rise of supply_en and compares the count with N+2. It does this for every pin with alternating levels, for all six debounce codes, and for a pulse that is cut short before it is driven again. The status value read after each wake must hold exactly the pins driven in that test.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   localparam int unsigned REG_W        = 32;
   localparam logic [7:0]  SHDN_KEY     = 8'hA5;
   localparam int unsigned KEY_LSB      = 24;
   localparam int unsigned MODE_DBC_LSB = 24;
   localparam int unsigned MODE_DBC_W   = 3;
   localparam int unsigned MODE_RTC_BIT = 17;
   localparam int unsigned STAT_RTC_BIT = 5;
   localparam int unsigned STAT_PIN_LSB = 16;
   localparam int unsigned WCFG_LVL_LSB = 16;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_MODE = 2'd1,
      SEL_STAT = 2'd2,
      SEL_WCFG = 2'd3
   } reg_sel_t;

   typedef struct packed {
      logic [MODE_DBC_W-1:0] dbc;
      logic                  rtc_en;
   } mode_t;

endpackage

// File: rtl/pwc_regs.sv
module pwc_regs
   import pwc_pkg::*;
#(
   parameter int unsigned NUM_WAKE = 16,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   input  logic [REG_W-1:0]    stat_word,
   output mode_t               mode_q,
   output logic [NUM_WAKE-1:0] pin_en_q,
   output logic [NUM_WAKE-1:0] pin_lvl_q,
   output logic                shdn_req,
   output logic                stat_clr,
   output logic [REG_W-1:0]    bus_rdata
);

   logic     in_range;
   reg_sel_t sel;
   logic     wr_hit_mode;
   logic     wr_hit_wcfg;
   logic [REG_W-1:0] mode_word;
   logic [REG_W-1:0] wcfg_word;

   assign in_range = ((bus_addr >> 4) == '0);
   assign sel      = reg_sel_t'(bus_addr[3:2]);

   assign wr_hit_mode = bus_wr && in_range && (sel == SEL_MODE);
   assign wr_hit_wcfg = bus_wr && in_range && (sel == SEL_WCFG);

   assign shdn_req = bus_wr && in_range && (sel == SEL_CMD) &&
                     bus_wdata[0] && (bus_wdata[KEY_LSB +: 8] == SHDN_KEY);
   assign stat_clr = bus_rd && in_range && (sel == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         pin_en_q  <= '0;
         pin_lvl_q <= '0;
      end else begin
         if (wr_hit_mode) begin
            mode_q.dbc    <= bus_wdata[MODE_DBC_LSB +: MODE_DBC_W];
            mode_q.rtc_en <= bus_wdata[MODE_RTC_BIT];
         end
         if (wr_hit_wcfg) begin
            pin_en_q  <= bus_wdata[0 +: NUM_WAKE];
            pin_lvl_q <= bus_wdata[WCFG_LVL_LSB +: NUM_WAKE];
         end
      end
   end

   always_comb begin
      mode_word = '0;
      mode_word[MODE_DBC_LSB +: MODE_DBC_W] = mode_q.dbc;
      mode_word[MODE_RTC_BIT]               = mode_q.rtc_en;
      wcfg_word = '0;
      wcfg_word[0 +: NUM_WAKE]            = pin_en_q;
      wcfg_word[WCFG_LVL_LSB +: NUM_WAKE] = pin_lvl_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         unique case (sel)
            SEL_CMD:  bus_rdata = '0;
            SEL_MODE: bus_rdata = mode_word;
            SEL_STAT: bus_rdata = stat_word;
            SEL_WCFG: bus_rdata = wcfg_word;
            default:  bus_rdata = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/pwc_wake_filter.sv
module pwc_wake_filter #(
   parameter int unsigned NUM_WAKE    = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] wake_pin,
   input  logic [NUM_WAKE-1:0] pin_en,
   input  logic [NUM_WAKE-1:0] pin_lvl,
   input  logic [CNT_W-1:0]    thr,
   input  logic                armed,
   output logic [NUM_WAKE-1:0] qual
);

   logic [NUM_WAKE-1:0] pin_s;
   logic [NUM_WAKE-1:0] act;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = wake_pin;
      end else begin : g_sync
         logic [NUM_WAKE-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= wake_pin;
               for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign pin_s = stg[SYNC_STAGES-1];
      end
   endgenerate

   assign act = pin_en & ~(pin_s ^ pin_lvl);

   generate
      for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!armed || !act[i]) begin
               cnt <= '0;
            end else if (cnt < thr) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign qual[i] = armed && act[i] && (cnt >= thr);
      end
   endgenerate

endmodule

// File: rtl/pwc_power_seq.sv
module pwc_power_seq #(
   parameter int unsigned NUM_WAKE = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shdn_req,
   input  logic [NUM_WAKE-1:0] qual,
   input  logic                rtc_alarm,
   input  logic                rtc_en,
   input  logic                stat_clr,
   output logic                supply_en,
   output logic [NUM_WAKE-1:0] stat_pins,
   output logic                stat_rtc
);

   logic rtc_hit;
   logic wake_fire;

   assign rtc_hit   = rtc_alarm && rtc_en;
   assign wake_fire = !supply_en && ((|qual) || rtc_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supply_en <= 1'b1;
      end else if (supply_en && shdn_req) begin
         supply_en <= 1'b0;
      end else if (wake_fire) begin
         supply_en <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_pins <= '0;
         stat_rtc  <= 1'b0;
      end else if (wake_fire) begin
         stat_pins <= qual;
         stat_rtc  <= rtc_hit;
      end else if (stat_clr) begin
         stat_pins <= '0;
         stat_rtc  <= 1'b0;
      end
   end

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwc_pkg::*;
#(
   parameter int unsigned NUM_WAKE    = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DBC_L1      = 3,
   parameter int unsigned DBC_L2      = 32,
   parameter int unsigned DBC_L3      = 512,
   parameter int unsigned DBC_L4      = 4096,
   parameter int unsigned DBC_L5      = 32768
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_WAKE-1:0] wake_pin,
   input  logic                rtc_alarm,
   output logic                supply_en
);

   localparam int unsigned CNT_W = (DBC_L5 > 2) ? $clog2(DBC_L5) : 1;

   generate
      if (NUM_WAKE < 1 || NUM_WAKE > 16) begin : g_bad_nw
         $error("NUM_WAKE must be 1..16");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("ADDR_W must be at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (DBC_L1 < 1 || DBC_L2 < DBC_L1 || DBC_L3 < DBC_L2 ||
          DBC_L4 < DBC_L3 || DBC_L5 < DBC_L4) begin : g_bad_dbc
         $error("debounce lengths must be nonzero and non-decreasing");
      end
   endgenerate

   mode_t               mode_q;
   logic [NUM_WAKE-1:0] pin_en_q;
   logic [NUM_WAKE-1:0] pin_lvl_q;
   logic                shdn_req;
   logic                stat_clr;
   logic [NUM_WAKE-1:0] qual;
   logic [NUM_WAKE-1:0] stat_pins;
   logic                stat_rtc;
   logic [31:0]         stat_word;
   logic [CNT_W-1:0]    thr;
   logic                rtc_en_w;

   assign rtc_en_w = mode_q.rtc_en;

   always_comb begin
      unique case (mode_q.dbc)
         3'd0:    thr = '0;
         3'd1:    thr = CNT_W'(DBC_L1 - 1);
         3'd2:    thr = CNT_W'(DBC_L2 - 1);
         3'd3:    thr = CNT_W'(DBC_L3 - 1);
         3'd4:    thr = CNT_W'(DBC_L4 - 1);
         default: thr = CNT_W'(DBC_L5 - 1);
      endcase
   end

   always_comb begin
      stat_word = '0;
      stat_word[STAT_PIN_LSB +: NUM_WAKE] = stat_pins;
      stat_word[STAT_RTC_BIT]             = stat_rtc;
   end

   pwc_regs #(.NUM_WAKE(NUM_WAKE), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .stat_word (stat_word),
      .mode_q    (mode_q),
      .pin_en_q  (pin_en_q),
      .pin_lvl_q (pin_lvl_q),
      .shdn_req  (shdn_req),
      .stat_clr  (stat_clr),
      .bus_rdata (bus_rdata)
   );

   pwc_wake_filter #(
      .NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
   ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_pin (wake_pin),
      .pin_en   (pin_en_q),
      .pin_lvl  (pin_lvl_q),
      .thr      (thr),
      .armed    (!supply_en),
      .qual     (qual)
   );

   pwc_power_seq #(.NUM_WAKE(NUM_WAKE)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .shdn_req  (shdn_req),
      .qual      (qual),
      .rtc_alarm (rtc_alarm),
      .rtc_en    (rtc_en_w),
      .stat_clr  (stat_clr),
      .supply_en (supply_en),
      .stat_pins (stat_pins),
      .stat_rtc  (stat_rtc)
   );

endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              rtc_alarm,
   input logic              supply_en,
   input logic              rtc_en,
   input logic [31:0]       stat_word
);

   logic cmd_wr;
   logic good_key;
   logic stat_rd;

   assign cmd_wr   = bus_wr && (bus_addr == ADDR_W'(0));
   assign good_key = bus_wdata[0] && (bus_wdata[31:24] == 8'hA5);
   assign stat_rd  = bus_rd && (bus_addr == ADDR_W'(8));

   p_keyed_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_en && cmd_wr && good_key) |=> !supply_en);

   p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_en && cmd_wr && !good_key) |=> supply_en);

   p_rtc_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_en && rtc_alarm && rtc_en) |=> (supply_en && stat_word[5]));

   p_wake_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_en) |-> (stat_word != 32'd0));

   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_en && stat_rd) |=> (stat_word == 32'd0));

   p_on_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_en && !stat_rd) |=> $stable(stat_word));

endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rtc_alarm (rtc_alarm),
   .supply_en (supply_en),
   .rtc_en    (rtc_en_w),
   .stat_word (stat_word)
);

// File: tb/tb_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_wake_ctrl;

   localparam int NW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_wr, bus_rd;
   logic [3:0]    bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic [NW-1:0] wake_pin;
   logic          rtc_alarm;
   logic          supply_en;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pwr_wake_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .supply_en(supply_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic shut_down();
      reg_wr(4'h0, 32'hA500_0001);
   endtask

   task automatic wait_wake(output int k);
      k = 0;
      while (!supply_en && k < 40000) begin
         @(posedge clk); k++; @(negedge clk);
      end
   endtask

   function automatic int dbc_len(input int code);
      case (code)
         0: return 1;
         1: return 3;
         2: return 32;
         3: return 512;
         4: return 4096;
         default: return 32768;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int k;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
      bus_wdata = '0; wake_pin = '0; rtc_alarm = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      check("R1 supply after reset", 32'(supply_en), 32'd1);
      reg_rd(4'h8, rd); check("R1 status after reset", rd, 32'd0);

      // R4 register layout and readback
      reg_wr(4'h4, 32'h0502_0000);
      reg_rd(4'h4, rd); check("R4 mode readback", rd, 32'h0502_0000);
      reg_wr(4'h4, 32'hFFFF_FFFF);
      reg_rd(4'h4, rd); check("R4 mode masked", rd, 32'h0702_0000);
      reg_wr(4'hC, 32'h1234_ABCD);
      reg_rd(4'hC, rd); check("R4 wake cfg readback", rd, 32'h1234_ABCD);
      reg_rd(4'h0, rd); check("R4 command reads zero", rd, 32'd0);

      // R11 zero configuration
      reg_wr(4'h4, 32'd0);
      reg_wr(4'hC, 32'd0);

      // R3 bad key / missing command bit
      reg_wr(4'h0, 32'h5A00_0001);
      check("R3 wrong key ignored", 32'(supply_en), 32'd1);
      reg_wr(4'h0, 32'hA500_0000);
      check("R3 bit0 clear ignored", 32'(supply_en), 32'd1);

      // R2 keyed shutdown
      shut_down();
      check("R2 keyed shutdown", 32'(supply_en), 32'd0);

      // R11 all wake disabled; R8 alarm ignored with enable clear
      for (int c = 0; c < 50; c++) begin
         wake_pin = (c % 2 == 0) ? '1 : '0;
         rtc_alarm = (c % 5 == 0);
         @(negedge clk);
      end
      rtc_alarm = 1'b0; wake_pin = '0;
      check("R11 no wake with zero config", 32'(supply_en), 32'd0);

      // R8 alarm wake
      reg_wr(4'h4, 32'h0002_0000);
      check("R8 still off before pulse", 32'(supply_en), 32'd0);
      rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
      check("R8 alarm wakes", 32'(supply_en), 32'd1);
      reg_rd(4'h8, rd); check("R8 status alarm bit", rd, 32'h0000_0020);
      reg_rd(4'h8, rd); check("R9 status cleared by read", rd, 32'd0);

      // R5 R6 R9 sweep over every pin, alternating level, code 1
      for (int i = 0; i < NW; i++) begin
         logic pol;
         pol = i[0];
         wake_pin = pol ? '0 : '1;
         reg_wr(4'h4, 32'h0100_0000);
         reg_wr(4'hC, (32'(pol) << (16 + i)) | (32'd1 << i));
         shut_down();
         wake_pin[i] = pol;
         wait_wake(k);
         check($sformatf("R6 pin %0d wake latency", i), 32'(k), 32'd5);
         reg_rd(4'h8, rd);
         check($sformatf("R9 pin %0d status", i), rd, 32'd1 << (16 + i));
      end

      // R5 disabled pin and wrong level never wake
      wake_pin = '0;
      reg_wr(4'h4, 32'd0);
      reg_wr(4'hC, 32'h0004_0004);
      shut_down();
      wake_pin = 16'hFFFB;
      repeat (20) @(negedge clk);
      check("R5 other pins and low level ignored", 32'(supply_en), 32'd0);
      wake_pin[2] = 1'b1;
      wait_wake(k);
      check("R5 enabled pin at level wakes", 32'(k), 32'd3);
      reg_rd(4'h8, rd); check("R5 status pin 2 only", rd, 32'h0004_0000);

      // R6 every debounce code, pin 0 active low
      for (int code = 0; code < 6; code++) begin
         wake_pin = '1;
         reg_wr(4'hC, 32'h0000_0001);
         reg_wr(4'h4, 32'(code) << 24);
         shut_down();
         wake_pin[0] = 1'b0;
         wait_wake(k);
         check($sformatf("R6 code %0d latency", code), 32'(k), 32'(dbc_len(code) + 2));
         reg_rd(4'h8, rd);
      end

      // R7 interrupted count restarts, code 2
      wake_pin = '0;
      reg_wr(4'hC, 32'h0002_0002);
      reg_wr(4'h4, 32'h0200_0000);
      shut_down();
      wake_pin[1] = 1'b1;
      repeat (20) @(negedge clk);
      check("R7 no wake before count", 32'(supply_en), 32'd0);
      wake_pin[1] = 1'b0;
      repeat (2) @(negedge clk);
      wake_pin[1] = 1'b1;
      wait_wake(k);
      check("R7 count restarted", 32'(k), 32'd34);
      reg_rd(4'h8, rd);

      // R9 two pins on the same wake edge
      wake_pin = '0;
      reg_wr(4'h4, 32'd0);
      reg_wr(4'hC, 32'h0088_0088);
      shut_down();
      wake_pin[3] = 1'b1; wake_pin[7] = 1'b1;
      wait_wake(k);
      check("R9 two pin wake latency", 32'(k), 32'd3);
      reg_rd(4'h8, rd); check("R9 both pins recorded", rd, 32'h0088_0000);

      // R10 events while powered leave status alone
      reg_wr(4'h4, 32'h0002_0000);
      rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
      repeat (10) @(negedge clk);
      reg_rd(4'h8, rd); check("R10 status unchanged while on", rd, 32'd0);
      check("R10 supply still on", 32'(supply_en), 32'd1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule